// File: doc/BRIEF.md
# Configuration Request Beat Packer

This block turns one configuration request into a short packet on a beat stream. A request is made of three 32-bit header dwords, one 32-bit write-data dword, the register offset of the target and a read/write flag. It is accepted on a valid/ready port. The block then sends two, three or four beats downstream. Each beat carries two 32-bit lanes plus start-of-packet and end-of-packet flags, and every beat waits for the downstream ready.

In the default dual-lane build, the register offset decides where the data dword lands. If the offset sits on a quadword boundary, the header's third dword gets a beat of its own and the data follows in a third beat. Otherwise the data rides in lane 1 beside that header dword and the packet ends one beat sooner.

A parameter selects a single-lane build. That build always emits four beats, one dword per beat, with lane 1 held at zero. Read requests go out with a zero data dword but follow the same layout. Header construction and completion handling belong to other blocks.

Top module: `cfg_tx_packer`

## Requirements
- R1: After reset, and after reset is applied in the middle of a packet, `req_ready_o` is 1 and `beat_valid_o` is 0.
- R2: The first beat of every packet carries header dword 0 in lane 0 and header dword 1 in lane 1 (dual-lane build), with the start flag 1 and the end flag 0.
- R3: Dual-lane build, offset quadword aligned: the second beat carries header dword 2 in lane 0 and zero in lane 1, with both flags 0.
- R4: Dual-lane build, offset quadword aligned: the third and last beat carries the data dword in lane 0 and zero in lane 1, with only the end flag set.
- R5: Dual-lane build, offset not quadword aligned: the second beat is the last one and carries header dword 2 in lane 0 and the data dword in lane 1, with only the end flag set.
- R6: An offset is quadword aligned when its bits [2:0] are all zero. A dual-lane packet has exactly 3 beats when the offset is aligned and exactly 2 when it is not. No beat follows the end-flagged beat.
- R7: When `req_is_read_i` is 1, the data dword sent is zero whatever `req_data_i` holds, and the beat layout is the same as for a write.
- R8: Single-lane build: every packet is four beats, in the order header 0 with the start flag, header 1, header 2, then data with the end flag. Lane 1 is zero on every beat.
- R9: While a packet is in flight, `req_ready_o` is 0 and a request held valid on the port is not taken. No beat appears without an accepted request.
- R10: While `beat_valid_o` is 1 and `beat_ready_i` is 0, the beat's lanes and flags stay unchanged on the next cycle.
- R11: `req_ready_o` is 1 whenever the block is idle. It returns to 1 in the cycle after the end-flagged beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_hdr0_i | input | 32 | Header dword 0 |
| req_hdr1_i | input | 32 | Header dword 1 |
| req_hdr2_i | input | 32 | Header dword 2 |
| req_data_i | input | 32 | Write data dword |
| req_offset_i | input | OFF_W (12) | Target register offset; bits [2:0] set alignment |
| req_is_read_i | input | 1 | Request is a read; data sent as zero |
| beat_valid_o | output | 1 | Beat present |
| beat_ready_i | input | 1 | Downstream takes the beat |
| beat_lane0_o | output | 32 | Lane 0 dword |
| beat_lane1_o | output | 32 | Lane 1 dword |
| beat_sop_o | output | 1 | Start-of-packet flag |
| beat_eop_o | output | 1 | End-of-packet flag |

## Verification
The hardest case to reach from the ports is a new request held valid across the whole of a packet. The block must ignore it right up to the edge where it goes idle. The stimulus holds the request valid for the entire packet and drops it only while the end beat is waiting. It then watches the beat port for several idle cycles to confirm that nothing was taken. Backpressure is applied before every beat of some vectors, so each beat kind is seen stalled. Offsets of 1, 4 and 12 sit next to aligned offsets 0, 8 and 0x3F8, so the alignment decision is exercised on both sides.

// File: rtl/cfg_tx_pkg.sv
package cfg_tx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned QW_BITS = 3;
  localparam int unsigned IDX_W   = 2;

  typedef struct packed {
    logic [WORD_W-1:0] lane0;
    logic [WORD_W-1:0] lane1;
    logic              sop;
    logic              eop;
  } beat_t;
endpackage

// File: rtl/cfg_tx_capture.sv
module cfg_tx_capture
  import cfg_tx_pkg::*;
#(
  parameter int unsigned OFF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] hdr0_i,
  input  logic [WORD_W-1:0] hdr1_i,
  input  logic [WORD_W-1:0] hdr2_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              is_rd_i,
  output logic [WORD_W-1:0] hdr0_o,
  output logic [WORD_W-1:0] hdr1_o,
  output logic [WORD_W-1:0] hdr2_o,
  output logic [WORD_W-1:0] data_o,
  output logic              aligned_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr0_o    <= '0;
      hdr1_o    <= '0;
      hdr2_o    <= '0;
      data_o    <= '0;
      aligned_o <= 1'b0;
    end else if (load_i) begin
      hdr0_o    <= hdr0_i;
      hdr1_o    <= hdr1_i;
      hdr2_o    <= hdr2_i;
      data_o    <= is_rd_i ? '0 : data_i;  // reads carry a zero payload
      aligned_o <= (offset_i[QW_BITS-1:0] == '0);
    end
  end
endmodule

// File: rtl/cfg_tx_seq.sv
module cfg_tx_seq
  import cfg_tx_pkg::*;
#(
  parameter bit DUAL_LANE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             aligned_i,
  input  logic             beat_ready_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] last_idx;

  generate
    if (DUAL_LANE) begin : g_dual
      assign last_idx = aligned_i ? IDX_W'(2) : IDX_W'(1);
    end else begin : g_single
      assign last_idx = IDX_W'(3);
    end
  endgenerate

  assign last_o = (idx_o == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end else if (busy_o && beat_ready_i) begin
      if (last_o) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + IDX_W'(1);
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (idx_o <= last_idx)); // R6
endmodule

// File: rtl/cfg_tx_mux.sv
module cfg_tx_mux
  import cfg_tx_pkg::*;
#(
  parameter bit DUAL_LANE = 1'b1
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              aligned_i,
  input  logic [WORD_W-1:0] hdr0_i,
  input  logic [WORD_W-1:0] hdr1_i,
  input  logic [WORD_W-1:0] hdr2_i,
  input  logic [WORD_W-1:0] data_i,
  output beat_t             beat_o
);
  generate
    if (DUAL_LANE) begin : g_dual
      always_comb begin
        beat_o = '0;
        unique case (idx_i)
          IDX_W'(0): begin
            beat_o.lane0 = hdr0_i;
            beat_o.lane1 = hdr1_i;
            beat_o.sop   = 1'b1;
          end
          IDX_W'(1): begin
            beat_o.lane0 = hdr2_i;
            if (!aligned_i) begin
              beat_o.lane1 = data_i;
              beat_o.eop   = 1'b1;
            end
          end
          IDX_W'(2): begin
            beat_o.lane0 = data_i;
            beat_o.eop   = 1'b1;
          end
          default: beat_o = '0;
        endcase
      end
    end else begin : g_single
      always_comb begin
        beat_o = '0;
        unique case (idx_i)
          IDX_W'(0): begin
            beat_o.lane0 = hdr0_i;
            beat_o.sop   = 1'b1;
          end
          IDX_W'(1): beat_o.lane0 = hdr1_i;
          IDX_W'(2): beat_o.lane0 = hdr2_i;
          default: begin
            beat_o.lane0 = data_i;
            beat_o.eop   = 1'b1;
          end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_tx_packer.sv
module cfg_tx_packer
  import cfg_tx_pkg::*;
#(
  parameter int unsigned OFF_W     = 12,
  parameter bit          DUAL_LANE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [WORD_W-1:0] req_hdr0_i,
  input  logic [WORD_W-1:0] req_hdr1_i,
  input  logic [WORD_W-1:0] req_hdr2_i,
  input  logic [WORD_W-1:0] req_data_i,
  input  logic [OFF_W-1:0]  req_offset_i,
  input  logic              req_is_read_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [WORD_W-1:0] beat_lane0_o,
  output logic [WORD_W-1:0] beat_lane1_o,
  output logic              beat_sop_o,
  output logic              beat_eop_o
);
  logic              busy, start, aligned_q, last;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] hdr0_q, hdr1_q, hdr2_q, data_q;
  beat_t             beat;

  assign start       = req_valid_i && !busy;
  assign req_ready_o = !busy;

  cfg_tx_capture #(.OFF_W(OFF_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .hdr0_i   (req_hdr0_i),
    .hdr1_i   (req_hdr1_i),
    .hdr2_i   (req_hdr2_i),
    .data_i   (req_data_i),
    .offset_i (req_offset_i),
    .is_rd_i  (req_is_read_i),
    .hdr0_o   (hdr0_q),
    .hdr1_o   (hdr1_q),
    .hdr2_o   (hdr2_q),
    .data_o   (data_q),
    .aligned_o(aligned_q)
  );

  cfg_tx_seq #(.DUAL_LANE(DUAL_LANE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .aligned_i   (aligned_q),
    .beat_ready_i(beat_ready_i),
    .busy_o      (busy),
    .idx_o       (idx),
    .last_o      (last)
  );

  cfg_tx_mux #(.DUAL_LANE(DUAL_LANE)) u_mux (
    .idx_i    (idx),
    .aligned_i(aligned_q),
    .hdr0_i   (hdr0_q),
    .hdr1_i   (hdr1_q),
    .hdr2_i   (hdr2_q),
    .data_i   (data_q),
    .beat_o   (beat)
  );

  assign beat_valid_o = busy;
  assign beat_lane0_o = beat.lane0;
  assign beat_lane1_o = beat.lane1;
  assign beat_sop_o   = beat.sop;
  assign beat_eop_o   = beat.eop;

  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_lane0_o) && $stable(beat_lane1_o) && $stable(beat_sop_o) && $stable(beat_eop_o)); // R10
  AST_SOP_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> beat_valid_o && beat_sop_o && !beat_eop_o); // R2
  AST_READY_AFTER_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && beat_eop_o |=> req_ready_o && !beat_valid_o); // R11
  AST_NO_UNASKED_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(beat_valid_o) |-> $past(req_valid_i)); // R9
  AST_EOP_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (beat_eop_o == last)); // R6

  generate
    if (!DUAL_LANE) begin : g_chk_single
      AST_LANE1_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_valid_o |-> (beat_lane1_o == '0)); // R8
    end
  endgenerate
endmodule

// File: tb/cfg_tx_packer_bench.sv
`timescale 1ns/1ps
module cfg_tx_packer_bench;
  localparam int OFF_W = 12;

  typedef struct packed {
    logic [31:0]      h0, h1, h2, d;
    logic [OFF_W-1:0] off;
    logic             rd;
    logic             stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0440_0001, 32'h0000_10FF, 32'h0108_0000, 32'hDEAD_BEEF, 12'h000, 1'b0, 1'b0},
    '{32'h0440_0001, 32'h0000_1003, 32'h0208_0004, 32'h1234_5678, 12'h004, 1'b0, 1'b1},
    '{32'h0440_0001, 32'h0000_100F, 32'h0300_0008, 32'hA5A5_5A5A, 12'h008, 1'b0, 1'b1},
    '{32'h0400_0001, 32'h0000_1D0F, 32'h0400_000C, 32'hFFFF_FFFF, 12'h00C, 1'b1, 1'b0},
    '{32'h0400_0001, 32'h0000_1D0F, 32'h0500_0010, 32'h8765_4321, 12'h010, 1'b1, 1'b1},
    '{32'h0440_0001, 32'h0000_1002, 32'h0600_0001, 32'h0BAD_F00D, 12'h001, 1'b0, 1'b0},
    '{32'h0450_0001, 32'h0000_100C, 32'h0700_03F8, 32'hC0DE_CAFE, 12'h3F8, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] hdr0, hdr1, hdr2, data;
  logic [OFF_W-1:0] off;
  logic is_rd;
  logic vld_d = 1'b0, vld_s = 1'b0, brdy_d = 1'b0, brdy_s = 1'b0;
  logic rr_d, rr_s, bv_d, bv_s, sop_d, sop_s, eop_d, eop_s;
  logic [31:0] l0_d, l1_d, l0_s, l1_s;

  cfg_tx_packer #(.OFF_W(OFF_W), .DUAL_LANE(1'b1)) u_cfg_tx_packer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld_d), .req_ready_o(rr_d),
    .req_hdr0_i(hdr0), .req_hdr1_i(hdr1), .req_hdr2_i(hdr2), .req_data_i(data),
    .req_offset_i(off), .req_is_read_i(is_rd), .beat_valid_o(bv_d), .beat_ready_i(brdy_d),
    .beat_lane0_o(l0_d), .beat_lane1_o(l1_d), .beat_sop_o(sop_d), .beat_eop_o(eop_d));

  cfg_tx_packer #(.OFF_W(OFF_W), .DUAL_LANE(1'b0)) u_cfg_tx_packer_sl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld_s), .req_ready_o(rr_s),
    .req_hdr0_i(hdr0), .req_hdr1_i(hdr1), .req_hdr2_i(hdr2), .req_data_i(data),
    .req_offset_i(off), .req_is_read_i(is_rd), .beat_valid_o(bv_s), .beat_ready_i(brdy_s),
    .beat_lane0_o(l0_s), .beat_lane1_o(l1_s), .beat_sop_o(sop_s), .beat_eop_o(eop_s));

  logic sel_s = 1'b0;
  logic o_rr, o_bv, o_sop, o_eop;
  logic [31:0] o_l0, o_l1;
  always_comb begin
    o_rr  = sel_s ? rr_s  : rr_d;
    o_bv  = sel_s ? bv_s  : bv_d;
    o_sop = sel_s ? sop_s : sop_d;
    o_eop = sel_s ? eop_s : eop_d;
    o_l0  = sel_s ? l0_s  : l0_d;
    o_l1  = sel_s ? l1_s  : l1_d;
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_vld(input logic v);
    if (sel_s) vld_s = v; else vld_d = v;
  endtask
  task automatic set_brdy(input logic v);
    if (sel_s) brdy_s = v; else brdy_d = v;
  endtask

  // Expected beat {lane0, lane1, sop, eop} from the requirements
  function automatic logic [65:0] exp_beat(input bit single, input int b, input vec_t v);
    logic [31:0] dd;
    bit al;
    dd = v.rd ? 32'h0 : v.d;
    al = (v.off[2:0] == 3'b000);
    if (single) begin
      case (b)
        0: return {v.h0, 32'h0, 1'b1, 1'b0};
        1: return {v.h1, 32'h0, 1'b0, 1'b0};
        2: return {v.h2, 32'h0, 1'b0, 1'b0};
        default: return {dd, 32'h0, 1'b0, 1'b1};
      endcase
    end
    case (b)
      0: return {v.h0, v.h1, 1'b1, 1'b0};
      1: return al ? {v.h2, 32'h0, 1'b0, 1'b0} : {v.h2, dd, 1'b0, 1'b1};
      default: return {dd, 32'h0, 1'b0, 1'b1};
    endcase
  endfunction

  function automatic string tag_of(input bit single, input int b, input vec_t v);
    if (v.rd && b > 0) return "R7";
    if (single) return "R8";
    if (b == 0) return "R2";
    if (v.off[2:0] != 3'b000) return "R5";
    return (b == 1) ? "R3" : "R4";
  endfunction

  task automatic run_pkt(input bit single, input vec_t v, input bit hold_req);
    int nb;
    logic [65:0] snap, e;
    nb = single ? 4 : ((v.off[2:0] == 3'b000) ? 3 : 2);
    @(negedge clk);
    sel_s = single;
    hdr0 = v.h0; hdr1 = v.h1; hdr2 = v.h2; data = v.d; off = v.off; is_rd = v.rd;
    chk("R11 idle ready", {63'h0, o_rr}, 64'h1);
    set_vld(1'b1);
    @(negedge clk);
    if (!hold_req) set_vld(1'b0);
    else begin
      hdr0 = ~v.h0; hdr1 = ~v.h1;  // a different request held on the port
    end
    for (int b = 0; b < nb; b++) begin
      if (v.stall) begin
        set_brdy(1'b0);
        snap = {o_l0, o_l1, o_sop, o_eop};
        @(negedge clk);
        chk("R10 hold", {o_bv, o_l0, o_l1[30:0]}, {1'b1, snap[65:34], snap[32:2]});
        chk("R10 flags", {62'h0, o_sop, o_eop}, {62'h0, snap[1:0]});
      end
      set_brdy(1'b1);
      if (hold_req && b == nb - 1) set_vld(1'b0);
      e = exp_beat(single, b, v);
      chk(tag_of(single, b, v), {o_l0, o_l1}, e[65:2]);
      chk({tag_of(single, b, v), " flags"}, {61'h0, o_bv, o_sop, o_eop}, {61'h0, 1'b1, e[1:0]});
      chk("R9 busy", {63'h0, o_rr}, 64'h0);
      @(negedge clk);
      set_brdy(1'b0);
    end
    chk(single ? "R8 count" : "R6 count", {63'h0, o_bv}, 64'h0);
    chk("R11 ready back", {63'h0, o_rr}, 64'h1);
    if (hold_req) begin
      repeat (3) @(negedge clk);
      chk("R9 held request ignored", {63'h0, o_bv}, 64'h0);
    end
  endtask

  initial begin
    hdr0 = '0; hdr1 = '0; hdr2 = '0; data = '0; off = '0; is_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {62'h0, rr_d, rr_s}, 64'h3);
    chk("R1 reset valid", {62'h0, bv_d, bv_s}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {60'h0, rr_d, rr_s, bv_d, bv_s}, 64'hC);

    for (int i = 0; i < NV; i++) run_pkt(1'b0, VECS[i], 1'b0);
    for (int i = 0; i < NV; i++) run_pkt(1'b1, VECS[i], 1'b0);

    // request held valid through a whole packet
    run_pkt(1'b0, VECS[2], 1'b1);
    run_pkt(1'b1, VECS[5], 1'b1);

    // reset in the middle of a packet
    @(negedge clk);
    sel_s = 1'b0;
    hdr0 = VECS[0].h0; hdr1 = VECS[0].h1; hdr2 = VECS[0].h2;
    data = VECS[0].d; off = VECS[0].off; is_rd = 1'b0;
    vld_d = 1'b1;
    @(negedge clk);
    vld_d = 1'b0;
    chk("R2 mid start", {62'h0, bv_d, sop_d}, 64'h3);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", {62'h0, rr_d, bv_d}, 64'h2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 stays idle", {62'h0, rr_d, bv_d}, 64'h2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule